// File: doc/BRIEF.md
# Transforming Scratchpad RAM Controller

This block holds a 256-byte scratchpad that a CPU bus reads and writes. It is reached through a 2 KB address window in which the storage repeats, so only the low eight address bits pick a cell. A 12-bit mode word, sampled with each access, changes how the access behaves. It can move the cell index, force either nibble of the written byte, or write a value back into a cell just after that cell has been read. One mode bit also asks an external interrupt latch to clear when software stores zero. The latch itself is outside this block.

A read is accepted on a clock edge, and its data appears on `rdData` with `rdValid` for the following cycle. An internal last-read register takes each byte that is read, unless the mode holds it. If a read requests a write-back, the block spends one extra cycle committing the new cell value and raises `busy`. Any strobe offered during that cycle is dropped, so the bus must repeat it.

Top module: `scratch_xform`

## Requirements
- R1: Only address bits 7:0 select a cell. The higher bits of `cpuAddr` are ignored, so each cell repeats every 256 bytes across the window.
- R2: A read taken on an edge returns the cell on `rdData` with `rdValid` high in the next cycle. With mode bit 0 set, the read uses the cell index with its bit 7 inverted. Writes are not affected by this bit.
- R3: With mode bit 1 set, a write stores to the index rotated left by two, so index bits 7:6 become bits 1:0. Reads are not affected by this bit.
- R4: On a write, mode bit 2 forces the stored low nibble to 0 and mode bit 3 forces it to F. When both bits are set the low nibble is 0.
- R5: On a write, mode bit 4 forces the stored high nibble to 0 and mode bit 5 forces it to F. When both bits are set the high nibble is 0.
- R6: After a read, the cell that was read is rewritten as follows: mode bit 6 writes 00, bit 7 writes FF, and bit 8 writes the cell's own index. The index is the one after any inversion by bit 0. When several of these bits are set, the candidates are combined by bitwise AND.
- R7: With mode bit 9 set, a read writes the previous last-read value into the cell just read. The last-read register then takes the new data. This candidate is ANDed with any others from R6.
- R8: The last-read register loads the read data on every read, unless mode bit 11 is set. With bit 11 set, the register keeps its value.
- R9: `clrLatchReq` pulses high for one cycle after an accepted write whose CPU data is 00 while mode bit 10 is set. No other access raises it.
- R10: A read with any of mode bits 9:6 set holds `busy` high for exactly the one following cycle. A read or write strobe presented while `busy` is high has no effect.
- R11: After reset, `rdValid`, `busy` and `clrLatchReq` are low and the last-read register holds 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 11 | Offset within the 2 KB window; bits 7:0 used |
| rdStb | input | 1 | Read request, one cycle per access |
| wrStb | input | 1 | Write request, one cycle per access |
| wrData | input | 8 | Write data |
| modeWord | input | 12 | Per-access transformation controls |
| rdData | output | 8 | Data of the last accepted read |
| rdValid | output | 1 | `rdData` refers to the read accepted on the previous edge |
| busy | output | 1 | Write-back cycle in progress; strobes are dropped |
| clrLatchReq | output | 1 | One-cycle request to clear the interrupt latch |

## Verification
The assertions assume that a read strobe and a write strobe are never high in the same cycle. They also assume the mode word is steady while the strobe is high. The stimulus raises one strobe for one cycle at a time and waits out `busy` before the next access. The one exception is a directed test that deliberately drives a write during `busy` to show that it is dropped. Each cell is written before it is read, because cell contents are not defined after reset.

// File: rtl/scratch_pkg.sv
package scratch_pkg;
  localparam int MB_RD_FLIP   = 0;
  localparam int MB_WR_ROT    = 1;
  localparam int MB_LO_ZERO   = 2;
  localparam int MB_LO_ONES   = 3;
  localparam int MB_HI_ZERO   = 4;
  localparam int MB_HI_ONES   = 5;
  localparam int MB_WB_ZERO   = 6;
  localparam int MB_WB_ONES   = 7;
  localparam int MB_WB_INDEX  = 8;
  localparam int MB_WB_LAST   = 9;
  localparam int MB_CLR_ZERO  = 10;
  localparam int MB_HOLD_LAST = 11;
  localparam int MODE_W       = 12;
  localparam int NIB_CNT      = 2;

  typedef struct packed {
    logic doRead;
    logic doWrite;
    logic doWb;
    logic loadLast;
    logic clrReq;
  } ctlStrobes_t;
endpackage

// File: rtl/scratch_ctl.sv
module scratch_ctl
  import scratch_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [MODE_W-1:0] modeWord,
  output ctlStrobes_t       strb,
  output logic              busy
);
  typedef enum logic {ST_IDLE, ST_WBACK} ctlState_t;
  ctlState_t state;
  logic wbNeeded;
  logic [5:0] unusedMode;

  assign unusedMode = modeWord[5:0];
  assign wbNeeded   = |modeWord[MB_WB_LAST:MB_WB_ZERO];
  assign busy       = (state == ST_WBACK);

  always_comb begin
    strb          = '0;
    strb.doRead   = rdStb && !busy;
    strb.doWrite  = wrStb && !rdStb && !busy;
    strb.doWb     = busy;
    strb.loadLast = strb.doRead && !modeWord[MB_HOLD_LAST];
    strb.clrReq   = strb.doWrite && modeWord[MB_CLR_ZERO] && (wrData == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else if (strb.doRead && wbNeeded) state <= ST_WBACK;
    else state <= ST_IDLE;
  end

  // R10: the write-back phase lasts a single cycle
  p_wb_one_cycle_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);
  // R10: a read asking for write-back enters the busy cycle
  p_wb_entry_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && !busy && (|modeWord[MB_WB_LAST:MB_WB_ZERO])) |=> busy);
endmodule

// File: rtl/scratch_dp.sv
module scratch_dp
  import scratch_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctlStrobes_t              strb,
  input  logic [$clog2(DEPTH)-1:0] cellIdx,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [MB_WB_LAST:0]      modeBits,
  output logic [DATA_W-1:0]        rdData,
  output logic                     rdValid,
  output logic                     clrLatchReq
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int NIB_W = DATA_W / NIB_CNT;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  rdIdx, wrIdx, capIdx;
  logic [DATA_W-1:0] forced, wbCand, wbVal, lastRead;

  // read index: optional inversion of the top index bit
  assign rdIdx = cellIdx ^ {modeBits[MB_RD_FLIP], {(IDX_W-1){1'b0}}};
  // write index: optional rotate left by two
  assign wrIdx = modeBits[MB_WR_ROT] ? {cellIdx[IDX_W-3:0], cellIdx[IDX_W-1:IDX_W-2]}
                                     : cellIdx;

  // nibble forcing; force-to-ones applied first, force-to-zero wins (AND rule)
  for (genvar n = 0; n < NIB_CNT; n++) begin : g_nib
    logic [NIB_W-1:0] nibVal;
    always_comb begin
      nibVal = wrData[n*NIB_W +: NIB_W];
      if (modeBits[MB_LO_ONES + 2*n]) nibVal = '1;
      if (modeBits[MB_LO_ZERO + 2*n]) nibVal = '0;
    end
    assign forced[n*NIB_W +: NIB_W] = nibVal;
  end

  // write-back candidate: AND of every selected source
  always_comb begin
    wbCand = '1;
    if (modeBits[MB_WB_ZERO])  wbCand = '0;
    if (modeBits[MB_WB_INDEX]) wbCand = wbCand & DATA_W'(rdIdx);
    if (modeBits[MB_WB_LAST])  wbCand = wbCand & lastRead;
  end

  always_ff @(posedge clk) begin
    if (strb.doWrite)   mem[wrIdx]  <= forced;
    else if (strb.doWb) mem[capIdx] <= wbVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData      <= '0;
      rdValid     <= 1'b0;
      clrLatchReq <= 1'b0;
      lastRead    <= '0;
      capIdx      <= '0;
      wbVal       <= '0;
    end else begin
      rdValid     <= strb.doRead;
      clrLatchReq <= strb.clrReq;
      if (strb.doRead) begin
        rdData <= mem[rdIdx];
        capIdx <= rdIdx;
        wbVal  <= wbCand;
      end
      if (strb.loadLast) lastRead <= mem[rdIdx];
    end
  end

  // R8: a read that must not update the last-read register leaves it as it was
  p_last_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doRead && !strb.loadLast) |=> $stable(lastRead));
  // R6: the write-back store never coincides with a CPU write
  p_wb_no_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.doWb |-> !strb.doWrite);
endmodule

// File: rtl/scratch_xform.sv
module scratch_xform
  import scratch_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [MODE_W-1:0] modeWord,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              busy,
  output logic              clrLatchReq
);
  localparam int IDX_W = $clog2(DEPTH);

  ctlStrobes_t strb;
  logic unusedHigh;

  assign unusedHigh = ^cpuAddr[ADDR_W-1:IDX_W];

  scratch_ctl #(.DATA_W(DATA_W)) i_ctl (
    .clk(clk), .rstN(rstN), .rdStb(rdStb), .wrStb(wrStb),
    .wrData(wrData), .modeWord(modeWord), .strb(strb), .busy(busy)
  );

  scratch_dp #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cellIdx(cpuAddr[IDX_W-1:0]),
    .wrData(wrData), .modeBits(modeWord[MB_WB_LAST:0]), .rdData(rdData),
    .rdValid(rdValid), .clrLatchReq(clrLatchReq)
  );

  // R2: valid data only follows an accepted read
  p_valid_after_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rdStb && !busy));
  // R9: the clear request only follows a zero write with the clear bit set
  p_clr_source_r9: assert property (@(posedge clk) disable iff (!rstN)
    clrLatchReq |-> $past(wrStb && !busy && wrData == '0 && modeWord[MB_CLR_ZERO]));
  // R9: reads never raise the clear request
  p_clr_not_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && !wrStb) |=> !clrLatchReq);
endmodule

// File: tb/test_scratch_xform.sv
module test_scratch_xform;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [10:0] cpuAddr = '0;
  logic rdStb = 1'b0, wrStb = 1'b0;
  logic [7:0] wrData = '0;
  logic [11:0] modeWord = '0;
  logic [7:0] rdData;
  logic rdValid, busy, clrLatchReq;
  int nRun = 0, nFail = 0;

  always #5 clk = ~clk;

  scratch_xform i_scratch_xform (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .rdStb(rdStb), .wrStb(wrStb),
    .wrData(wrData), .modeWord(modeWord), .rdData(rdData), .rdValid(rdValid),
    .busy(busy), .clrLatchReq(clrLatchReq)
  );

  typedef struct packed {
    logic        isRead;
    logic [10:0] addr;
    logic [7:0]  data;
    logic [11:0] mode;
    logic [7:0]  expd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 48;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 11'h005, 8'h3C, 12'h000, 8'h00, 4'd1},  // R1
    '{1'b1, 11'h005, 8'h00, 12'h000, 8'h3C, 4'd1},
    '{1'b1, 11'h705, 8'h00, 12'h000, 8'h3C, 4'd1},  // R1 mirror
    '{1'b0, 11'h085, 8'hA5, 12'h000, 8'h00, 4'd2},
    '{1'b1, 11'h005, 8'h00, 12'h001, 8'hA5, 4'd2},  // R2 flip
    '{1'b1, 11'h085, 8'h00, 12'h001, 8'h3C, 4'd2},
    '{1'b0, 11'h041, 8'h77, 12'h002, 8'h00, 4'd3},  // R3 rotate to 05
    '{1'b1, 11'h005, 8'h00, 12'h000, 8'h77, 4'd3},
    '{1'b0, 11'h010, 8'h96, 12'h004, 8'h00, 4'd4},  // R4
    '{1'b1, 11'h010, 8'h00, 12'h000, 8'h90, 4'd4},
    '{1'b0, 11'h011, 8'h96, 12'h008, 8'h00, 4'd4},
    '{1'b1, 11'h011, 8'h00, 12'h000, 8'h9F, 4'd4},
    '{1'b0, 11'h012, 8'h96, 12'h00C, 8'h00, 4'd4},
    '{1'b1, 11'h012, 8'h00, 12'h000, 8'h90, 4'd4},
    '{1'b0, 11'h013, 8'h96, 12'h010, 8'h00, 4'd5},  // R5
    '{1'b1, 11'h013, 8'h00, 12'h000, 8'h06, 4'd5},
    '{1'b0, 11'h014, 8'h96, 12'h020, 8'h00, 4'd5},
    '{1'b1, 11'h014, 8'h00, 12'h000, 8'hF6, 4'd5},
    '{1'b0, 11'h015, 8'h96, 12'h030, 8'h00, 4'd5},
    '{1'b1, 11'h015, 8'h00, 12'h000, 8'h06, 4'd5},
    '{1'b0, 11'h016, 8'h96, 12'h028, 8'h00, 4'd5},
    '{1'b1, 11'h016, 8'h00, 12'h000, 8'hFF, 4'd5},
    '{1'b0, 11'h020, 8'h5A, 12'h000, 8'h00, 4'd6},  // R6
    '{1'b1, 11'h020, 8'h00, 12'h040, 8'h5A, 4'd6},
    '{1'b1, 11'h020, 8'h00, 12'h000, 8'h00, 4'd6},
    '{1'b0, 11'h021, 8'h5A, 12'h000, 8'h00, 4'd6},
    '{1'b1, 11'h021, 8'h00, 12'h080, 8'h5A, 4'd6},
    '{1'b1, 11'h021, 8'h00, 12'h000, 8'hFF, 4'd6},
    '{1'b0, 11'h022, 8'h5A, 12'h000, 8'h00, 4'd6},
    '{1'b1, 11'h022, 8'h00, 12'h100, 8'h5A, 4'd6},
    '{1'b1, 11'h022, 8'h00, 12'h000, 8'h22, 4'd6},
    '{1'b0, 11'h023, 8'h5A, 12'h000, 8'h00, 4'd6},
    '{1'b1, 11'h023, 8'h00, 12'h180, 8'h5A, 4'd6},
    '{1'b1, 11'h023, 8'h00, 12'h000, 8'h23, 4'd6},
    '{1'b0, 11'h0A4, 8'h11, 12'h000, 8'h00, 4'd6},
    '{1'b1, 11'h024, 8'h00, 12'h101, 8'h11, 4'd6},  // index after flip
    '{1'b1, 11'h0A4, 8'h00, 12'h000, 8'hA4, 4'd6},  // last-read = A4
    '{1'b0, 11'h030, 8'h12, 12'h000, 8'h00, 4'd7},  // R7
    '{1'b1, 11'h030, 8'h00, 12'h200, 8'h12, 4'd7},
    '{1'b1, 11'h030, 8'h00, 12'h000, 8'hA4, 4'd7},  // last-read = A4
    '{1'b0, 11'h032, 8'h55, 12'h000, 8'h00, 4'd8},  // R8
    '{1'b1, 11'h032, 8'h00, 12'h800, 8'h55, 4'd8},  // held at A4
    '{1'b0, 11'h033, 8'h66, 12'h000, 8'h00, 4'd8},
    '{1'b1, 11'h033, 8'h00, 12'h200, 8'h66, 4'd8},
    '{1'b1, 11'h033, 8'h00, 12'h000, 8'hA4, 4'd8},  // last-read = A4
    '{1'b0, 11'h034, 8'h3C, 12'h000, 8'h00, 4'd7},
    '{1'b1, 11'h034, 8'h00, 12'h280, 8'h3C, 4'd7},  // FF & A4
    '{1'b1, 11'h034, 8'h00, 12'h000, 8'hA4, 4'd7}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [10:0] a, input logic [7:0] d, input logic [11:0] m,
                         output logic clrSeen);
    @(negedge clk);
    cpuAddr = a; wrData = d; modeWord = m; wrStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0; modeWord = '0;
    clrSeen = clrLatchReq;
  endtask

  task automatic doRead(input logic [10:0] a, input logic [11:0] m,
                        output logic [7:0] d, output logic v);
    @(negedge clk);
    cpuAddr = a; modeWord = m; rdStb = 1'b1;
    @(negedge clk);
    rdStb = 1'b0; modeWord = '0;
    d = rdData; v = rdValid;
    while (busy) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    logic v, c;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(rdValid == 1'b0, "R11 rdValid", rdValid, 0);
    check(busy == 1'b0, "R11 busy", busy, 0);
    check(clrLatchReq == 1'b0, "R11 clrLatchReq", clrLatchReq, 0);
    rstN = 1'b1;
    // R11 last-read resets to 00: expose it via write-back
    doWrite(11'h040, 8'h77, 12'h000, c);
    doRead(11'h040, 12'h200, d, v);
    check(d == 8'h77, "R11 read", d, 8'h77);
    doRead(11'h040, 12'h000, d, v);
    check(d == 8'h00, "R11 last-read reset", d, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].isRead) begin
        doRead(VEC[i].addr, VEC[i].mode, d, v);
        check(v == 1'b1, $sformatf("R2 rdValid vec %0d", i), v, 1);
        check(d == VEC[i].expd, $sformatf("R%0d vec %0d", VEC[i].req, i), d, VEC[i].expd);
      end else begin
        doWrite(VEC[i].addr, VEC[i].data, VEC[i].mode, c);
      end
    end

    // R9 clear request
    doWrite(11'h050, 8'h00, 12'h400, c);
    check(c == 1'b1, "R9 zero write", c, 1);
    @(negedge clk);
    check(clrLatchReq == 1'b0, "R9 one-cycle pulse", clrLatchReq, 0);
    doWrite(11'h050, 8'h00, 12'h000, c);
    check(c == 1'b0, "R9 bit clear", c, 0);
    doWrite(11'h050, 8'h01, 12'h400, c);
    check(c == 1'b0, "R9 nonzero data", c, 0);
    doWrite(11'h051, 8'h00, 12'h404, c);
    check(c == 1'b1, "R9 forced zero write", c, 1);
    doRead(11'h050, 12'h400, d, v);
    @(negedge clk);
    check(clrLatchReq == 1'b0, "R9 read no request", clrLatchReq, 0);

    // R10 busy window and stalled strobe
    doWrite(11'h060, 8'h11, 12'h000, c);
    doWrite(11'h061, 8'h22, 12'h000, c);
    @(negedge clk);
    cpuAddr = 11'h061; modeWord = 12'h040; rdStb = 1'b1;
    @(negedge clk);
    rdStb = 1'b0; modeWord = '0;
    check(busy == 1'b1, "R10 busy after write-back read", busy, 1);
    cpuAddr = 11'h060; wrData = 8'hEE; wrStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0;
    check(busy == 1'b0, "R10 busy one cycle", busy, 0);
    doRead(11'h060, 12'h000, d, v);
    check(d == 8'h11, "R10 stalled write dropped", d, 8'h11);
    doRead(11'h061, 12'h000, d, v);
    check(d == 8'h00, "R10 write-back committed", d, 8'h00);
    @(negedge clk);
    cpuAddr = 11'h060; rdStb = 1'b1;
    @(negedge clk);
    rdStb = 1'b0;
    check(busy == 1'b0, "R10 no busy without write-back", busy, 0);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule